// File: doc/BRIEF.md
# Multiprocessor-Capable Start-Stop Serial Transceiver

This block is a full-duplex asynchronous serial port. The transmit half takes a character from a parallel write strobe and sends it on `txd` as a frame: a low start bit, seven or eight data bits, an optional extra bit, then one or two high stop bits. The receive half watches `rxd`, rebuilds characters in the same format and reports them on a parallel side with status flags. Both halves share one format setting. They run at the same time and do not depend on each other. A one-cycle enable, `tick16`, fires sixteen times per bit period. Dividing the system clock down to that rate is left to the surrounding logic.

The extra bit after the data has one of two uses. It can be a parity bit, even or odd. Or, in multiprocessor mode, it is a flag that marks the character as a station address (1) or as data (0). A receiver can be set to accept only address characters, so data sent to other stations is dropped without disturbing its registers. Each direction has a holding register in front of its shift register, so characters stream back to back. The receiver flags parity, framing and overrun errors separately. It also exposes the synchronised line level, so software can tell a break condition from a corrupted character.

Top module: `mpuart_top`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `tx_empty` is 1, `rx_full` is 0 and all three error flags are 0.
- R2: A transmitted frame is built as follows: start bit 0, then the data bits, then the extra bit if parity or multiprocessor mode is on, then one stop bit of 1 (two when `cfg_stop2`=1). Every bit lasts 16 `tick16` pulses, and `txd` is 1 whenever no frame is being sent.
- R3: With 8-bit data, `cfg_msb_first`=1 sends `tx_byte[7]` first and 0 sends `tx_byte[0]` first. With `cfg_len7`=1, bits 0..6 always go LSB first, `tx_byte[7]` is not sent and `rx_byte[7]` reads 0.
- R4: With parity on (`cfg_par_en`=1, `cfg_mp_en`=0), the parity bit makes the count of ones over data plus parity even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1). On a mismatch the receiver sets `rx_err_parity` and still stores the data.
- R5: With `cfg_mp_en`=1, the extra bit carries `tx_flag` instead of parity, whatever `cfg_par_en` is set to. The receiver returns that bit on `rx_flag` and never flags a parity error.
- R6: With `cfg_mp_en`=1 and `rx_addr_only`=1, a received character whose flag is 0 is discarded and leaves `rx_full`, the stored data and the flags unchanged. A character whose flag is 1 is accepted.
- R7: `tx_wr` is accepted only while `tx_empty`=1, which drops to 0 on the next cycle. A write while `tx_empty`=0 is ignored. A character waiting in the holding register starts on the tick that ends the previous stop bit, so frames follow each other with no idle time.
- R8: The receiver checks a start bit at its midpoint, 8 ticks after it is detected. A low pulse that has returned high by then does not start a character.
- R9: If a character completes while `rx_full`=1, `rx_err_overrun` is set, the new character is dropped, and `rx_byte`/`rx_flag` keep the unread character.
- R10: `rx_err_frame` is set when any stop bit is sampled low. `rxd_level` shows the synchronised `rxd` level, so a line still held low after a framing error marks a break. `rx_ack` clears `rx_full` and all error flags.
- R11: In loopback, every combination of length, stop count, extra-bit mode and bit order returns the sent character and flag with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sub-bit enable, 16 per bit period |
| cfg_len7 | input | 1 | 1: seven data bits, 0: eight |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_par_en | input | 1 | Parity enable (ignored in multiprocessor mode) |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_mp_en | input | 1 | Multiprocessor flag bit in place of parity |
| cfg_msb_first | input | 1 | MSB-first order for 8-bit data |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_byte | input | 8 | Character to transmit |
| tx_flag | input | 1 | Address/data flag to transmit |
| tx_empty | output | 1 | Transmit holding register can accept a write |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_ack | input | 1 | Clears received-full and error flags |
| rx_addr_only | input | 1 | Discard characters whose flag is 0 |
| rx_byte | output | 8 | Last accepted character |
| rx_flag | output | 1 | Flag of the last accepted character |
| rx_full | output | 1 | Unread character present |
| rx_err_parity | output | 1 | Parity mismatch |
| rx_err_frame | output | 1 | Stop bit sampled low |
| rx_err_overrun | output | 1 | Character lost while full |
| rxd_level | output | 1 | Synchronised line level |

## Verification
The bench sweeps all 32 format and order combinations in loopback and decodes `txd` on its own. A design that reversed the order for 7-bit data, or put the extra bit in the wrong slot, would fail on the frame bits. It measures the spacing between two back-to-back frames; a transmitter that inserted an idle tick before fetching the holding register would show a longer period. It drives corrupted frames, a break, a short start glitch and an overrun on `rxd`, expecting the old data to survive the overrun and the glitch to be ignored. It also sends data characters with address-only filtering on, which a receiver that stored them would reveal through `rx_full`.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

  localparam int FRAME_MAX = 12;   // start + 8 data + extra + 2 stop

  typedef struct packed {
    logic len7;
    logic stop2;
    logic par_en;
    logic par_odd;
    logic mp_en;
    logic msb_first;
  } fmt_t;

  // Data bits rearranged into line order (index 0 leaves first).
  // The mapping is its own inverse, so the receiver reuses it.
  function automatic logic [7:0] wire_order(input logic [7:0] d, input fmt_t f);
    logic [7:0] r;
    r = d;
    if (f.len7) r = {1'b0, d[6:0]};
    else if (f.msb_first) for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction

  function automatic logic has_extra(input fmt_t f);
    return f.mp_en | f.par_en;
  endfunction

  function automatic logic [3:0] data_len(input fmt_t f);
    return f.len7 ? 4'd7 : 4'd8;
  endfunction

  function automatic logic extra_bit(input logic [7:0] d, input logic flag, input fmt_t f);
    logic [7:0] m;
    m = f.len7 ? {1'b0, d[6:0]} : d;
    if (f.mp_en) return flag;
    return f.par_odd ? ~(^m) : (^m);
  endfunction

endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx
  import mpuart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       wr,
  input  logic [7:0] wr_data,
  input  logic       wr_flag,
  output logic       empty,
  output logic       busy,
  output logic       txd
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [7:0]           hold_q;
  logic                 hold_flag_q, hold_full_q, hold_full_n;
  logic [FRAME_MAX-1:0] sh_q, sh_n;
  logic [3:0]           left_q, left_n;
  logic [SUB_W-1:0]     sub_q, sub_n;
  logic                 busy_q, busy_n, txd_q, take;

  function automatic logic [FRAME_MAX-1:0] build(input logic [7:0] d, input logic fl,
                                                 input fmt_t f);
    logic [FRAME_MAX-1:0] b;
    logic [7:0] w;
    logic [3:0] n;
    b = '1;
    w = wire_order(d, f);
    n = data_len(f);
    b[0] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < int'(n)) b[i+1] = w[i];
    if (has_extra(f)) b[n+4'd1] = extra_bit(d, fl, f);
    return b;
  endfunction

  function automatic logic [3:0] frame_len(input fmt_t f);
    return 4'd2 + data_len(f) + {3'b0, has_extra(f)} + {3'b0, f.stop2};
  endfunction

  always_comb begin
    sh_n   = sh_q;
    left_n = left_q;
    sub_n  = sub_q;
    busy_n = busy_q;
    take   = 1'b0;
    if (busy_q && tick) begin
      if (sub_q == SUB_LAST) begin
        sub_n = '0;
        if (left_q == 4'd1) busy_n = 1'b0;
        else begin
          sh_n   = {1'b1, sh_q[FRAME_MAX-1:1]};
          left_n = left_q - 4'd1;
        end
      end else begin
        sub_n = sub_q + 1'b1;
      end
    end
    if (!busy_n && hold_full_q) begin
      sh_n   = build(hold_q, hold_flag_q, fmt);
      left_n = frame_len(fmt);
      sub_n  = '0;
      busy_n = 1'b1;
      take   = 1'b1;
    end
    hold_full_n = hold_full_q & ~take;
    if (wr && !hold_full_q) hold_full_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0; hold_flag_q <= 1'b0; hold_full_q <= 1'b0;
      sh_q <= '1; left_q <= '0; sub_q <= '0; busy_q <= 1'b0; txd_q <= 1'b1;
    end else begin
      if (wr && !hold_full_q) begin
        hold_q      <= wr_data;
        hold_flag_q <= wr_flag;
      end
      hold_full_q <= hold_full_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      sub_q  <= sub_n;
      busy_q <= busy_n;
      txd_q  <= busy_n ? sh_n[0] : 1'b1;
    end
  end

  assign empty = ~hold_full_q;
  assign busy  = busy_q;
  assign txd   = txd_q;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       rxd,
  input  logic       ack,
  input  logic       addr_only,
  output logic [7:0] data,
  output logic       flag,
  output logic       full,
  output logic       perr,
  output logic       ferr,
  output logic       oerr,
  output logic       level
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_st_t;

  logic [SYNC-1:0]  sy_q;
  logic             rxd_s, level_q;
  rx_st_t           st_q;
  logic [SUB_W-1:0] sub_q;
  logic [3:0]       idx_q, n, stop_i, last_i;
  logic [15:0]      bits_q, bv;
  logic [7:0]       w_data;
  logic             ext, w_extra, w_flag, w_perr, w_ferr, done, skip;

  assign rxd_s = sy_q[SYNC-1];

  always_comb begin
    n       = data_len(fmt);
    ext     = has_extra(fmt);
    stop_i  = n + {3'b0, ext};
    last_i  = stop_i + {3'b0, fmt.stop2};
    bv      = bits_q;
    bv[idx_q] = rxd_s;
    w_data  = wire_order(bv[7:0], fmt);
    w_extra = bv[n];
    w_flag  = fmt.mp_en & w_extra;
    w_perr  = fmt.par_en & ~fmt.mp_en & (w_extra != extra_bit(w_data, 1'b0, fmt));
    w_ferr  = ~bv[stop_i] | (fmt.stop2 & ~bv[last_i]);
    done    = (st_q == S_BITS) && tick && (sub_q == SUB_LAST) && (idx_q == last_i);
    skip    = addr_only & fmt.mp_en & ~w_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sy_q <= '1; level_q <= 1'b1;
      st_q <= S_IDLE; sub_q <= '0; idx_q <= '0; bits_q <= '0;
      data <= '0; flag <= 1'b0; full <= 1'b0;
      perr <= 1'b0; ferr <= 1'b0; oerr <= 1'b0;
    end else begin
      sy_q    <= {sy_q[SYNC-2:0], rxd};
      level_q <= rxd_s;
      if (tick) begin
        case (st_q)
          S_IDLE: if (!rxd_s) begin st_q <= S_START; sub_q <= '0; end
          S_START:
            if (sub_q == SUB_MID) begin
              if (rxd_s) st_q <= S_IDLE;
              else begin st_q <= S_BITS; sub_q <= '0; idx_q <= '0; end
            end else sub_q <= sub_q + 1'b1;
          default:
            if (sub_q == SUB_LAST) begin
              sub_q  <= '0;
              bits_q <= bv;
              if (idx_q == last_i) st_q <= S_IDLE;
              else idx_q <= idx_q + 4'd1;
            end else sub_q <= sub_q + 1'b1;
        endcase
      end
      if (ack) begin
        full <= 1'b0; perr <= 1'b0; ferr <= 1'b0; oerr <= 1'b0;
      end
      if (done && !skip) begin
        if (full && !ack) oerr <= 1'b1;
        else begin
          data <= w_data; flag <= w_flag; full <= 1'b1;
          perr <= w_perr; ferr <= w_ferr;
        end
      end
    end
  end

  assign level = level_q;
endmodule

// File: rtl/mpuart_top.sv
module mpuart_top
  import mpuart_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       cfg_len7,
  input  logic       cfg_stop2,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_mp_en,
  input  logic       cfg_msb_first,
  input  logic       tx_wr,
  input  logic [7:0] tx_byte,
  input  logic       tx_flag,
  output logic       tx_empty,
  output logic       txd,
  input  logic       rxd,
  input  logic       rx_ack,
  input  logic       rx_addr_only,
  output logic [7:0] rx_byte,
  output logic       rx_flag,
  output logic       rx_full,
  output logic       rx_err_parity,
  output logic       rx_err_frame,
  output logic       rx_err_overrun,
  output logic       rxd_level
);
  fmt_t fmt;
  logic tx_busy;

  assign fmt = '{len7: cfg_len7, stop2: cfg_stop2, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, mp_en: cfg_mp_en, msb_first: cfg_msb_first};

  mpuart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick16), .fmt(fmt),
    .wr(tx_wr), .wr_data(tx_byte), .wr_flag(tx_flag),
    .empty(tx_empty), .busy(tx_busy), .txd(txd)
  );

  mpuart_rx #(.OVS(OVS), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst(rst), .tick(tick16), .fmt(fmt), .rxd(rxd),
    .ack(rx_ack), .addr_only(rx_addr_only),
    .data(rx_byte), .flag(rx_flag), .full(rx_full),
    .perr(rx_err_parity), .ferr(rx_err_frame), .oerr(rx_err_overrun),
    .level(rxd_level)
  );
endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_len7,
  input logic       cfg_mp_en,
  input logic       tx_wr,
  input logic       tx_empty,
  input logic       tx_busy,
  input logic       txd,
  input logic [7:0] rx_byte,
  input logic       rx_full,
  input logic       rx_err_parity,
  input logic       rx_err_frame,
  input logic       rx_err_overrun
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (txd && tx_empty && !rx_full && !rx_err_overrun && !rx_err_parity));

  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  a_r7_write_fills: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && tx_empty) |=> !tx_empty);

  a_r3_seven_bit_top_zero: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && cfg_len7) |-> !rx_byte[7]);

  a_r5_flag_mode_no_parity: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && cfg_mp_en) |-> !rx_err_parity);

  a_r9_overrun_keeps_data: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_err_overrun) |-> ($stable(rx_byte) && rx_full));

  a_r10_errors_need_full: assert property (@(posedge clk) disable iff (rst)
    (rx_err_parity || rx_err_frame || rx_err_overrun) |-> rx_full);
endmodule

bind mpuart_top mpuart_chk chk_i (
  .clk(clk), .rst(rst), .cfg_len7(cfg_len7), .cfg_mp_en(cfg_mp_en),
  .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_busy(tx_busy), .txd(txd),
  .rx_byte(rx_byte), .rx_full(rx_full), .rx_err_parity(rx_err_parity),
  .rx_err_frame(rx_err_frame), .rx_err_overrun(rx_err_overrun)
);

// File: tb/mpuart_top_tb_top.sv
module mpuart_top_tb_top;
  logic clk = 1'b0, rst = 1'b1, tick16 = 1'b0;
  logic cfg_len7 = 0, cfg_stop2 = 0, cfg_par_en = 1, cfg_par_odd = 0, cfg_mp_en = 0, cfg_msb_first = 0;
  logic tx_wr = 0, tx_flag = 0, rx_ack = 0, rx_addr_only = 0;
  logic [7:0] tx_byte = 8'h00;
  logic tx_empty, txd, rx_flag, rx_full, rx_err_parity, rx_err_frame, rx_err_overrun, rxd_level;
  logic [7:0] rx_byte;
  logic bb_sel = 1'b1, bb_line = 1'b1;
  logic rxd;
  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  logic [1:0] tcnt = 2'd0;
  int mode = 1;   // 0 none, 1 even, 2 odd, 3 flag
  logic track = 1'b0, prev_txd = 1'b1;
  int edge_t [8];
  int ne = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    tcnt   <= tcnt + 2'd1;
    tick16 <= (tcnt == 2'd2);
  end
  always @(negedge clk) begin
    if (track && prev_txd && !txd && ne < 8) begin edge_t[ne] = cyc; ne++; end
    prev_txd = txd;
  end

  assign rxd = bb_sel ? bb_line : txd;

  mpuart_top dut_i (
    .clk(clk), .rst(rst), .tick16(tick16),
    .cfg_len7(cfg_len7), .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en), .cfg_msb_first(cfg_msb_first),
    .tx_wr(tx_wr), .tx_byte(tx_byte), .tx_flag(tx_flag), .tx_empty(tx_empty), .txd(txd),
    .rxd(rxd), .rx_ack(rx_ack), .rx_addr_only(rx_addr_only),
    .rx_byte(rx_byte), .rx_flag(rx_flag), .rx_full(rx_full),
    .rx_err_parity(rx_err_parity), .rx_err_frame(rx_err_frame),
    .rx_err_overrun(rx_err_overrun), .rxd_level(rxd_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input int m);
    mode = m;
    cfg_mp_en   = (m == 3);
    cfg_par_en  = (m == 1 || m == 2);
    cfg_par_odd = (m == 2);
  endtask

  // Expected line bits for one frame, built from the requirements.
  task automatic expf(input logic [7:0] d, input logic fl, output logic [11:0] b, output int n);
    int nd, ones;
    logic bt;
    nd = cfg_len7 ? 7 : 8;
    ones = 0;
    b = '1;
    b[0] = 1'b0;
    n = 1;
    for (int k = 0; k < nd; k++) begin
      bt = (!cfg_len7 && cfg_msb_first) ? d[7-k] : d[k];
      b[n] = bt;
      ones += int'(bt);
      n++;
    end
    if (mode == 3) begin b[n] = fl; n++; end
    else if (mode == 1) begin b[n] = (ones % 2 == 1); n++; end
    else if (mode == 2) begin b[n] = (ones % 2 == 0); n++; end
    n += cfg_stop2 ? 2 : 1;
  endtask

  task automatic txw(input logic [7:0] d, input logic fl);
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    tx_byte = d; tx_flag = fl; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic wait_full(input int lim);
    int t = 0;
    while (!rx_full && t < lim) begin @(negedge clk); t++; end
  endtask

  task automatic decode_tx(input logic [11:0] b, input int n, input string tag);
    int to = 0;
    logic [11:0] got = '1;
    @(negedge clk);
    while (txd !== 1'b0 && to < 3000) begin @(negedge clk); to++; end
    repeat (32) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      repeat (64) @(negedge clk);
    end
    chk(tag, 32'(got), 32'(b));
  endtask

  task automatic bb_send(input logic [11:0] b, input int n);
    bb_sel = 1'b1;
    for (int i = 0; i < n; i++) begin
      bb_line = b[i];
      repeat (64) @(negedge clk);
    end
    bb_line = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [11:0] fb;
    int fn;
    logic [7:0] d;
    logic fl;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1); chk("R1 tx_empty", tx_empty, 1); chk("R1 rx_full", rx_full, 0);
    chk("R1 errors", {rx_err_parity, rx_err_frame, rx_err_overrun}, 0);
    chk("R10 level idle", rxd_level, 1);

    // R2 R3 R4 R5 R11 loopback sweep over all formats
    bb_sel = 1'b0;
    for (int c = 0; c < 32; c++) begin
      cfg_len7 = c[0]; cfg_stop2 = c[1]; cfg_msb_first = c[4];
      set_mode(int'(c[3:2]));
      for (int v = 0; v < 2; v++) begin
        d  = 8'(c * 29 + v * 113 + 7);
        fl = v[0] ^ c[0];
        expf(d, fl, fb, fn);
        txw(d, fl);
        decode_tx(fb, fn, "R2/R3/R4/R5 frame bits");
        wait_full(400);
        chk("R11 rx_full", rx_full, 1);
        chk("R11/R3 rx_byte", rx_byte, cfg_len7 ? {1'b0, d[6:0]} : d);
        chk("R5 rx_flag", rx_flag, (mode == 3) ? fl : 1'b0);
        chk("R11 no errors", {rx_err_parity, rx_err_frame, rx_err_overrun}, 0);
        do_ack();
        repeat (64) @(negedge clk);
      end
    end

    // default format: 8 bit, even parity, one stop, LSB first
    cfg_len7 = 0; cfg_stop2 = 0; cfg_msb_first = 0; set_mode(1);

    // R4 parity error via bit-banged frame
    expf(8'h5A, 1'b0, fb, fn);
    fb[9] = ~fb[9];
    bb_send(fb, fn);
    wait_full(200);
    chk("R4 parity error flag", rx_err_parity, 1);
    chk("R4 data kept on parity error", rx_byte, 8'h5A);
    chk("R4 no frame error", rx_err_frame, 0);
    do_ack();
    chk("R10 ack clears", {rx_full, rx_err_parity}, 0);

    // R10 framing error
    expf(8'h3C, 1'b0, fb, fn);
    fb[10] = 1'b0;
    bb_send(fb, fn);
    wait_full(200);
    chk("R10 frame error flag", rx_err_frame, 1);
    chk("R10 frame data", rx_byte, 8'h3C);
    do_ack();
    repeat (64) @(negedge clk);

    // R10 break: line held low
    bb_line = 1'b0;
    repeat (14 * 64) @(negedge clk);
    chk("R10 break frame error", rx_err_frame, 1);
    chk("R10 break data", rx_byte, 8'h00);
    chk("R10 break level", rxd_level, 0);
    bb_line = 1'b1;
    repeat (12 * 64) @(negedge clk);
    do_ack();
    repeat (100) @(negedge clk);
    do_ack();

    // R8 short start glitch
    bb_line = 1'b0;
    repeat (20) @(negedge clk);
    bb_line = 1'b1;
    repeat (15 * 64) @(negedge clk);
    chk("R8 glitch rejected", rx_full, 0);

    // R9 overrun in loopback
    bb_sel = 1'b0;
    txw(8'hC6, 1'b0);
    wait_full(2000);
    chk("R9 first char", rx_byte, 8'hC6);
    txw(8'h19, 1'b0);
    repeat (1000) @(negedge clk);
    chk("R9 overrun flag", rx_err_overrun, 1);
    chk("R9 old data kept", rx_byte, 8'hC6);
    do_ack();
    chk("R10 ack clears overrun", {rx_full, rx_err_overrun}, 0);
    repeat (100) @(negedge clk);

    // R7 back-to-back spacing (receiver isolated)
    bb_sel = 1'b1; bb_line = 1'b1;
    ne = 0; track = 1'b1;
    txw(8'h00, 1'b0);
    txw(8'h00, 1'b0);
    txw(8'h00, 1'b0);
    repeat (3 * 11 * 64) @(negedge clk);
    track = 1'b0;
    chk("R7 three starts", ne, 3);
    chk("R7 no gap between frames", edge_t[2] - edge_t[1], 11 * 64);

    // R7 write ignored while holding register full
    bb_sel = 1'b0;
    @(negedge clk); tx_byte = 8'h11; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    @(negedge clk);
    chk("R7 holding drained to shifter", tx_empty, 1);
    tx_byte = 8'h22; tx_wr = 1'b1;
    @(negedge clk);
    chk("R7 holding full after write", tx_empty, 0);
    tx_byte = 8'h33;
    @(negedge clk); tx_wr = 1'b0;
    chk("R7 still full", tx_empty, 0);
    wait_full(2000);
    chk("R7 first of pair", rx_byte, 8'h11);
    do_ack();
    wait_full(2000);
    chk("R7 second of pair", rx_byte, 8'h22);
    do_ack();
    repeat (2000) @(negedge clk);
    chk("R7 ignored write not sent", rx_full, 0);
    chk("R7 transmitter idle", tx_empty, 1);

    // R6 address-only filtering
    set_mode(3); rx_addr_only = 1'b1;
    txw(8'h12, 1'b0);
    repeat (1000) @(negedge clk);
    chk("R6 data char discarded", rx_full, 0);
    txw(8'h47, 1'b1);
    wait_full(1000);
    chk("R6 address accepted", rx_full, 1);
    chk("R6 address byte", rx_byte, 8'h47);
    chk("R6 address flag", rx_flag, 1);
    do_ack();
    rx_addr_only = 1'b0;

    finish_run();
  end
endmodule